// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This block sits between a keyboard character source and a 16-bit processor bus. The source offers an 8-bit character code together with a one-cycle valid strobe. The port captures one character at a time and holds it until software collects it. Software finds the port at two fixed bus addresses: a status word and a data word.

The status word reports whether a character is waiting. It also holds an interrupt-enable bit that software can set or clear. The data word returns the held character. Reading the data word is the acknowledgement: it frees the port to take the next keystroke. Keystrokes that arrive while a character is still waiting are discarded, so the held character is never overwritten.

An interrupt request line is raised while a character is waiting and software has enabled interrupts. A hit output tells the surrounding bus logic that the address belongs to this port, so that the port's read data is used instead of memory.

Top module: `kbd_input_port`

## Requirements
- R1: `busHit` is 1 exactly when `busAddr` equals 16'hFE00 (status word) or 16'hFE02 (data word). For any other address, `busRData` is zero.
- R2: When no character is waiting and `keyValid` is 1, the port captures `keyCode` on that clock edge, and the waiting flag becomes 1.
- R3: A read at 16'hFE02 returns the held character in bits [7:0] and zeros in bits [15:8].
- R4: While the waiting flag is 1 and the data word is not being read in that cycle, strobes on `keyValid` are dropped. The held character and the waiting flag stay unchanged.
- R5: A cycle with `busRd`=1 at 16'hFE02 clears the waiting flag at the clock edge that ends the cycle. A read of the status word leaves the waiting flag unchanged.
- R6: A cycle with `busWr`=1 at 16'hFE00 loads `busWData[14]` into the interrupt-enable bit. The waiting flag cannot be set by this write.
- R7: `irqReq` is 1 exactly when the waiting flag and the interrupt-enable bit are both 1.
- R8: A read at 16'hFE00 returns the waiting flag in bit 15 and the interrupt-enable bit in bit 14. All other bits are zero.
- R9: While `rstN` is low, the waiting flag, the interrupt-enable bit and the held character are cleared.
- R10: If `keyValid` is 1 in the same cycle as a data-word read, the read returns the old character. The new character is captured on that edge, and the waiting flag stays 1.
- R11: A write at 16'hFE02 changes neither the held character nor the waiting flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyCode | input | 8 | Character code from the keyboard source |
| keyValid | input | 1 | One-cycle strobe qualifying `keyCode` |
| busAddr | input | 16 | Bus address |
| busRd | input | 1 | Bus read strobe |
| busWr | input | 1 | Bus write strobe |
| busWData | input | 16 | Bus write data |
| busRData | output | 16 | Read data of the addressed register, combinational from the address |
| busHit | output | 1 | Address belongs to this port |
| irqReq | output | 1 | Interrupt request to the processor |

## Verification
Read data and the hit flag are combinational from the address and the current state. The bench therefore samples them in the same cycle as the request, while the clock is still low. Every state change is due one edge after its cause: character capture, clearing of the waiting flag, enable-bit writes, and the interrupt line that follows from them. The bench checks these just after the next rising edge, and through a later read. Each table row drives one bus cycle, checks the combinational values before the edge and checks `irqReq` after it. The same-cycle read/arrival case and reset are then run as directed tests.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

  // Strobes issued by the control to the datapath for one cycle
  typedef struct packed {
    logic loadChar;   // capture keyCode into the character register
    logic writeIe;    // load interrupt-enable from bus write data
    logic selStatus;  // address decodes to the status word
    logic selData;    // address decodes to the data word
  } portStrobes_t;

endpackage

// File: rtl/kbd_port_ctrl.sv
module kbd_port_ctrl
  import kbd_port_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] STATUS_ADDR = 16'hFE00,
  parameter logic [15:0] DATA_ADDR   = 16'hFE02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output portStrobes_t      strobes,
  output logic              readyFlag,
  output logic              busHit
);

  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A   = ADDR_W'(DATA_ADDR);

  logic hitStatus;
  logic hitData;
  logic dataRead;
  logic accept;

  always_comb begin
    hitStatus = (busAddr == STATUS_A);
    hitData   = (busAddr == DATA_A);
    dataRead  = busRd & hitData;
    // A read of the data word frees the slot in the same cycle
    accept    = keyValid & (~readyFlag | dataRead);
    busHit    = hitStatus | hitData;

    strobes.loadChar  = accept;
    strobes.writeIe   = busWr & hitStatus;
    strobes.selStatus = hitStatus;
    strobes.selData   = hitData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          readyFlag <= 1'b0;
    else if (accept)    readyFlag <= 1'b1;
    else if (dataRead)  readyFlag <= 1'b0;
  end

  // R2
  capture_sets_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && !readyFlag) |=> readyFlag);

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyFlag && !(busRd && busAddr == DATA_A)) |=> readyFlag);

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == DATA_A && !keyValid) |=> !readyFlag);

  // R6
  sw_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == STATUS_A && !keyValid && !readyFlag) |=> !readyFlag);

  // R10
  read_and_arrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyFlag && keyValid && busRd && busAddr == DATA_A) |=> readyFlag);

endmodule

// File: rtl/kbd_port_dpath.sv
module kbd_port_dpath
  import kbd_port_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int DATA_W    = 16,
  parameter int READY_BIT = 15,
  parameter int IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic              readyFlag,
  input  logic [CODE_W-1:0] keyCode,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              irqReq
);

  localparam int PAD_W = DATA_W - CODE_W;
  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << READY_BIT) | (DATA_W'(1) << IE_BIT);

  logic [CODE_W-1:0] charReg;
  logic              ieBit;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] dataWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charReg <= '0;
      ieBit   <= 1'b0;
    end else begin
      if (strobes.loadChar) charReg <= keyCode;
      if (strobes.writeIe)  ieBit   <= busWData[IE_BIT];
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[READY_BIT] = readyFlag;
    statusWord[IE_BIT]    = ieBit;
    dataWord              = {{PAD_W{1'b0}}, charReg};

    if (strobes.selStatus)    busRData = statusWord;
    else if (strobes.selData) busRData = dataWord;
    else                      busRData = '0;

    irqReq = readyFlag & ieBit;
  end

  // R3
  data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selData |-> (busRData[DATA_W-1:CODE_W] == '0));

  // R8
  status_spare_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selStatus |-> ((busRData & ~STATUS_MASK) == '0));

  // R4
  char_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadChar |=> $stable(charReg));

  // R6
  ie_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeIe |=> (ieBit == $past(busWData[IE_BIT])));

endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_port_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 16,
  parameter int          CODE_W      = 8,
  parameter logic [15:0] STATUS_ADDR = 16'hFE00,
  parameter logic [15:0] DATA_ADDR   = 16'hFE02,
  parameter int          READY_BIT   = 15,
  parameter int          IE_BIT      = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] keyCode,
  input  logic              keyValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              busHit,
  output logic              irqReq
);

  portStrobes_t strobes;
  logic         readyFlag;

  kbd_port_ctrl #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .DATA_ADDR   (DATA_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .keyValid  (keyValid),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .strobes   (strobes),
    .readyFlag (readyFlag),
    .busHit    (busHit)
  );

  kbd_port_dpath #(
    .CODE_W    (CODE_W),
    .DATA_W    (DATA_W),
    .READY_BIT (READY_BIT),
    .IE_BIT    (IE_BIT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .readyFlag (readyFlag),
    .keyCode   (keyCode),
    .busWData  (busWData),
    .busRData  (busRData),
    .irqReq    (irqReq)
  );

endmodule

// File: tb/kbd_input_port_bench.sv
module kbd_input_port_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  keyCode;
  logic        keyValid;
  logic [15:0] busAddr;
  logic        busRd;
  logic        busWr;
  logic [15:0] busWData;
  logic [15:0] busRData;
  logic        busHit;
  logic        irqReq;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  kbd_input_port u_kbd_input_port (
    .clk(clk), .rstN(rstN), .keyCode(keyCode), .keyValid(keyValid),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWData(busWData),
    .busRData(busRData), .busHit(busHit), .irqReq(irqReq)
  );

  typedef struct packed {
    logic        kv;
    logic [7:0]  key;
    logic        rd;
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [15:0] expR;    // checked before the edge when rd=1
    logic        expHit;  // checked before the edge when rd=1
    logic        expIrq;  // checked after the edge
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // kv key   rd   wr   addr      wdata     expR     hit  irq  req
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h0000, 1'b1, 1'b0, 8'd8 },  // R8 idle status
    '{1'b1, 8'h41, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'd2 },  // R2 capture
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h8000, 1'b1, 1'b0, 8'd2 },  // R2 ready seen
    '{1'b1, 8'h42, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'd4 },  // R4 dropped
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h8000, 1'b1, 1'b0, 8'd5 },  // R5 status read keeps
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE02, 16'h0000, 16'h0041, 1'b1, 1'b0, 8'd3 },  // R3 R4 old char
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h0000, 1'b1, 1'b0, 8'd5 },  // R5 cleared
    '{1'b0, 8'h00, 1'b0, 1'b1, 16'hFE00, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 8'd6 },  // R6 set ie only
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h4000, 1'b1, 1'b0, 8'd6 },  // R6 R8
    '{1'b1, 8'h5A, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 8'd7 },  // R7 irq rises
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'hC000, 1'b1, 1'b1, 8'd8 },  // R8 both bits
    '{1'b1, 8'h33, 1'b1, 1'b0, 16'hFE02, 16'h0000, 16'h005A, 1'b1, 1'b1, 8'd10},  // R10 old out, new in
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE02, 16'h0000, 16'h0033, 1'b1, 1'b0, 8'd10},  // R10 R7 new char
    '{1'b0, 8'h00, 1'b0, 1'b1, 16'hFE00, 16'h8000, 16'h0000, 1'b0, 1'b0, 8'd6 },  // R6 no sw set
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h0000, 1'b1, 1'b0, 8'd6 },  // R6 ready stays 0
    '{1'b0, 8'h00, 1'b0, 1'b1, 16'hFE02, 16'h1234, 16'h0000, 1'b0, 1'b0, 8'd11},  // R11 write data
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE02, 16'h0000, 16'h0033, 1'b1, 1'b0, 8'd11},  // R11 unchanged
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'hFE04, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'd1 }   // R1 miss
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    keyValid = 1'b0; keyCode = '0; busRd = 1'b0; busWr = 1'b0;
    busAddr = '0; busWData = '0;
  endtask

  // One bus cycle: drive at the falling edge, check comb outputs, then irq after the edge
  task automatic step(input vec_t v);
    @(negedge clk);
    keyValid = v.kv; keyCode = v.key; busRd = v.rd; busWr = v.wr;
    busAddr = v.addr; busWData = v.wdata;
    #1;
    if (v.rd) begin
      check($sformatf("R%0d rdata", v.req), busRData, v.expR);
      check($sformatf("R%0d hit", v.req), {15'd0, busHit}, {15'd0, v.expHit});
    end
    @(posedge clk);
    #1;
    check($sformatf("R%0d irq", v.req), {15'd0, irqReq}, {15'd0, v.expIrq});
    idle();
  endtask

  function automatic vec_t mk(logic kv, logic [7:0] key, logic rd, logic wr,
                              logic [15:0] addr, logic [15:0] wd, logic [15:0] er,
                              logic eh, logic ei, logic [7:0] rq);
    return '{kv, key, rd, wr, addr, wd, er, eh, ei, rq};
  endfunction

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 irq at reset", {15'd0, irqReq}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R1 status address hit with no strobe
    @(negedge clk);
    busAddr = 16'hFE00; #1;
    check("R1 hit no strobe", {15'd0, busHit}, 16'h0001);
    idle();

    // R9 reset clears held char, ready and enable
    step(mk(1'b0, 8'h00, 1'b0, 1'b1, 16'hFE00, 16'h4000, 16'h0, 1'b0, 1'b0, 8'd6));
    step(mk(1'b1, 8'h77, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0, 1'b0, 1'b1, 8'd7));
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R9 irq cleared", {15'd0, irqReq}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    step(mk(1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h0000, 1'b1, 1'b0, 8'd9));
    step(mk(1'b0, 8'h00, 1'b1, 1'b0, 16'hFE02, 16'h0000, 16'h0000, 1'b1, 1'b0, 8'd9));

    // R4 repeated strobes while waiting: first char survives
    step(mk(1'b1, 8'h61, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0, 1'b0, 1'b0, 8'd2));
    step(mk(1'b1, 8'h62, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0, 1'b0, 1'b0, 8'd4));
    step(mk(1'b1, 8'h63, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h8000, 1'b1, 1'b0, 8'd4));
    step(mk(1'b0, 8'h00, 1'b1, 1'b0, 16'hFE02, 16'h0000, 16'h0061, 1'b1, 1'b0, 8'd4));
    step(mk(1'b0, 8'h00, 1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h0000, 1'b1, 1'b0, 8'd5));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule